// File: doc/BRIEF.md
# Credit-Gated Multi-Lane Link Transmitter

This block drives the sending end of one physical link that is shared by several virtual lanes (virtual channels). An upstream source offers, for every lane, at most one flit at a time, tagged with a two-bit kind that tells whether it opens a packet, continues it, closes it, or is a whole packet by itself. Only the opening flit carries routing information. Every flit of a packet travels on the same lane, in order, and flits of different packets never mix within one lane.

For each lane the block keeps an ownership bit and a count of free buffer slots at the receiver. A flit is taken only when three things hold at once. Its lane must be in the right ownership state: free for an opening flit, held for a continuing or closing flit. The lane must have at least one credit. The lane must also win the link for that cycle in a round-robin choice. The accepted flit leaves on the link one cycle later, with its lane number, so that the receiver can steer it into the matching buffer. The receiver hands back one credit per lane for each slot it frees. To keep the link busy, the receiver's per-lane depth has to cover the credit round-trip time.

Top module: `vc_credit_sender`

## Requirements
- R1: After reset no flit is accepted or driven until a source offers one, every lane is free, and every lane holds `BUF_DEPTH` credits.
- R2: Flit kinds are encoded as 2'b00 continue, 2'b01 open, 2'b10 close, 2'b11 single (open and close). An open or single flit is accepted only on a free lane. Accepting an open flit makes the lane held.
- R3: A continue or close flit offered on a free lane is not accepted and is not driven on the link, however long it is offered.
- R4: Accepting a close or single flit leaves the lane free on the next cycle. An open flit offered on a held lane waits until the close flit of the current packet has been accepted.
- R5: A lane with zero credits accepts nothing. Each accepted flit uses one credit of its lane.
- R6: A credit return on a lane adds one credit. The count never exceeds `BUF_DEPTH`, and an assertion flags a return that would.
- R7: A credit return and an accepted flit on the same lane in the same cycle leave that lane's count unchanged.
- R8: At most one flit is accepted per cycle. Among eligible lanes, the search starts at the lane just after the one granted last (lane 0 after reset) and wraps around.
- R9: `in_ready[v]` is high in the cycle the flit of lane v is accepted. On the next cycle `link_valid` is high and `link_vc`, `link_kind` and `link_data` carry that lane's number, kind and data. `link_valid` is low after a cycle with no acceptance.
- R10: A lane whose `in_valid` bit is low is never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | NUM_VC | Per-lane flit offered |
| in_kind | input | 2*NUM_VC | Per-lane flit kind, lane v at bits [2v+1:2v] |
| in_data | input | DATA_W*NUM_VC | Per-lane flit payload, lane v at slice v |
| in_ready | output | NUM_VC | Per-lane acceptance in this cycle |
| credit_ret | input | NUM_VC | Per-lane credit return, one slot freed |
| link_valid | output | 1 | Flit on the link |
| link_vc | output | $clog2(NUM_VC) | Lane number of the flit on the link |
| link_kind | output | 2 | Kind of the flit on the link |
| link_data | output | DATA_W | Payload of the flit on the link |

## Verification
The two functions that can fall in the same cycle are a flit send, which takes a credit, and a credit return, which adds one on the same lane. A directed phase keeps a packet streaming on one lane while a credit comes back every cycle. It then stops the returns and counts how many more flits go through before the lane stalls; that count must equal the credits held before the overlap. Long legal traffic mixes random returns with random offers on every lane and checks grants and link contents each cycle against a bench-side credit, ownership and round-robin model.

// File: rtl/vcs_pkg.sv
package vcs_pkg;

  typedef enum logic [1:0] {
    FK_CONT   = 2'b00,
    FK_OPEN   = 2'b01,
    FK_CLOSE  = 2'b10,
    FK_SINGLE = 2'b11
  } flit_kind_e;

  function automatic logic kind_opens(input logic [1:0] k);
    return k[0];
  endfunction

  function automatic logic kind_closes(input logic [1:0] k);
    return k[1];
  endfunction

  // Next credit count: a send takes one, a return gives one, both cancel.
  // Saturates at the receiver depth so a stray return cannot wrap.
  function automatic int unsigned credit_step(input int unsigned cnt,
                                              input logic sent,
                                              input logic ret,
                                              input int unsigned depth);
    if (sent && !ret) return (cnt == 0) ? 0 : cnt - 1;
    if (ret && !sent) return (cnt >= depth) ? depth : cnt + 1;
    return cnt;
  endfunction

endpackage

// File: rtl/vcs_lane.sv
module vcs_lane import vcs_pkg::*; #(
  parameter int unsigned BUF_DEPTH = 4,
  localparam int unsigned CW = $clog2(BUF_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic          grant,
  input  logic          credit_ret,
  output logic          eligible,
  output logic          held,
  output logic [CW-1:0] credits
);

  logic has_credit;
  logic state_ok;
  logic will_hold;
  logic will_free;

  assign has_credit = (credits != '0);
  assign state_ok   = kind_opens(req_kind) ? !held : held;
  assign eligible   = req_valid && has_credit && state_ok;
  assign will_hold  = grant && kind_opens(req_kind) && !kind_closes(req_kind);
  assign will_free  = grant && kind_closes(req_kind);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held    <= 1'b0;
      credits <= CW'(BUF_DEPTH);
    end else begin
      if (will_hold)      held <= 1'b1;
      else if (will_free) held <= 1'b0;
      credits <= CW'(credit_step(int'(credits), grant, credit_ret, BUF_DEPTH));
    end
  end

  // R5: the arbiter never grants a lane that lacks a credit or is not ready
  a_r5_grant_needs_credit: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (credits != '0));
  a_r3_grant_right_state: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !kind_opens(req_kind)) |-> held);
  // R6: a return may never push the count beyond the receiver depth
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (credit_ret && !grant) |-> (credits < CW'(BUF_DEPTH)));
  a_r7_overlap_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && credit_ret) |=> $stable(credits));
  a_r4_close_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && kind_closes(req_kind)) |=> !held);
  a_r2_open_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && kind_opens(req_kind) && !kind_closes(req_kind)) |=> held);

endmodule

// File: rtl/vcs_rr_arb.sv
module vcs_rr_arb #(
  parameter int unsigned N = 4,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);

  logic [IW-1:0] start_q;
  logic [IW-1:0] win_idx;
  logic          any_win;

  always_comb begin
    gnt     = '0;
    win_idx = '0;
    any_win = 1'b0;
    for (int k = 0; k < int'(N); k++) begin
      int idx;
      idx = (int'(start_q) + k) % int'(N);
      if (!any_win && req[idx]) begin
        any_win  = 1'b1;
        win_idx  = IW'(idx);
        gnt[idx] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       start_q <= '0;
    else if (any_win) start_q <= (int'(win_idx) == int'(N) - 1) ? '0 : win_idx + 1'b1;
  end

  // R8: one winner at most, always among the requesters
  a_r8_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  a_r8_winner_requested: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);
  a_r8_no_idle_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |-> (gnt != '0));

endmodule

// File: rtl/vc_credit_sender.sv
module vc_credit_sender import vcs_pkg::*; #(
  parameter int unsigned NUM_VC    = 4,
  parameter int unsigned BUF_DEPTH = 4,
  parameter int unsigned DATA_W    = 16,
  localparam int unsigned VCW = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  localparam int unsigned CW  = $clog2(BUF_DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_VC-1:0]          in_valid,
  input  logic [2*NUM_VC-1:0]        in_kind,
  input  logic [DATA_W*NUM_VC-1:0]   in_data,
  output logic [NUM_VC-1:0]          in_ready,
  input  logic [NUM_VC-1:0]          credit_ret,
  output logic                       link_valid,
  output logic [VCW-1:0]             link_vc,
  output logic [1:0]                 link_kind,
  output logic [DATA_W-1:0]          link_data
);

  logic [NUM_VC-1:0] lane_elig;
  logic [NUM_VC-1:0] lane_held;
  logic [NUM_VC-1:0] lane_gnt;
  logic [CW-1:0]     lane_cred [NUM_VC];

  generate
    for (genvar v = 0; v < int'(NUM_VC); v++) begin : g_lane
      vcs_lane #(.BUF_DEPTH(BUF_DEPTH)) u_lane (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (in_valid[v]),
        .req_kind  (in_kind[2*v +: 2]),
        .grant     (lane_gnt[v]),
        .credit_ret(credit_ret[v]),
        .eligible  (lane_elig[v]),
        .held      (lane_held[v]),
        .credits   (lane_cred[v])
      );
    end
  endgenerate

  vcs_rr_arb #(.N(NUM_VC)) u_arb (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (lane_elig),
    .gnt  (lane_gnt)
  );

  assign in_ready = lane_gnt;

  logic              sel_any;
  logic [VCW-1:0]    sel_vc;
  logic [1:0]        sel_kind;
  logic [DATA_W-1:0] sel_data;

  always_comb begin
    sel_any  = 1'b0;
    sel_vc   = '0;
    sel_kind = '0;
    sel_data = '0;
    for (int v = 0; v < int'(NUM_VC); v++) begin
      if (lane_gnt[v]) begin
        sel_any  = 1'b1;
        sel_vc   = VCW'(v);
        sel_kind = in_kind[2*v +: 2];
        sel_data = in_data[DATA_W*v +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_valid <= 1'b0;
      link_vc    <= '0;
      link_kind  <= '0;
      link_data  <= '0;
    end else begin
      link_valid <= sel_any;
      if (sel_any) begin
        link_vc   <= sel_vc;
        link_kind <= sel_kind;
        link_data <= sel_data;
      end
    end
  end

  // R10: nothing is taken from a lane that offers nothing
  a_r10_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready & ~in_valid) == '0);
  // R9: the link shows a flit exactly one cycle after an acceptance
  a_r9_link_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready != '0) |=> link_valid);
  a_r9_link_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready == '0) |=> !link_valid);

endmodule

// File: tb/vc_credit_sender_bench.sv
module vc_credit_sender_bench;
  localparam int NV = 4;
  localparam int DEPTH = 4;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [NV-1:0]    b_valid;
  logic [1:0]       b_kind [NV];
  logic [DW-1:0]    b_data [NV];
  logic [NV-1:0]    b_ret;
  logic [2*NV-1:0]  in_kind;
  logic [DW*NV-1:0] in_data;
  logic [NV-1:0]    in_ready;
  logic             link_valid;
  logic [1:0]       link_vc;
  logic [1:0]       link_kind;
  logic [DW-1:0]    link_data;

  always_comb begin
    for (int v = 0; v < NV; v++) begin
      in_kind[2*v +: 2]  = b_kind[v];
      in_data[DW*v +: DW] = b_data[v];
    end
  end

  vc_credit_sender #(.NUM_VC(NV), .BUF_DEPTH(DEPTH), .DATA_W(DW)) u_vc_credit_sender (
    .clk(clk), .rst_n(rst_n), .in_valid(b_valid), .in_kind(in_kind),
    .in_data(in_data), .in_ready(in_ready), .credit_ret(b_ret),
    .link_valid(link_valid), .link_vc(link_vc), .link_kind(link_kind),
    .link_data(link_data));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench-side model
  int m_cred [NV];
  bit m_held [NV];
  int m_last;
  int last_gi;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic bit m_elig(input int v);
    if (!b_valid[v] || m_cred[v] <= 0) return 1'b0;
    return b_kind[v][0] ? !m_held[v] : m_held[v];
  endfunction

  // Caller drives inputs just after a falling edge, then calls step.
  task automatic step(input string tag);
    int gi;
    logic [NV-1:0] exp_rdy;
    logic [1:0] ek;
    logic [DW-1:0] ed;
    #1;
    gi = -1;
    for (int k = 1; k <= NV; k++) begin
      int v;
      v = (m_last + k) % NV;
      if (gi < 0 && m_elig(v)) gi = v;
    end
    exp_rdy = '0;
    if (gi >= 0) exp_rdy[gi] = 1'b1;
    check(in_ready == exp_rdy, tag, "in_ready", int'(in_ready), int'(exp_rdy));
    ek = (gi >= 0) ? b_kind[gi] : 2'b00;
    ed = (gi >= 0) ? b_data[gi] : '0;
    @(posedge clk);
    #1;
    check(link_valid == (gi >= 0), tag, "link_valid", int'(link_valid), int'(gi >= 0));
    if (gi >= 0) begin
      check(int'(link_vc) == gi, tag, "link_vc", int'(link_vc), gi);
      check(link_kind == ek, tag, "link_kind", int'(link_kind), int'(ek));
      check(link_data == ed, tag, "link_data", int'(link_data), int'(ed));
      m_cred[gi]--;
      if (ek == 2'b01) m_held[gi] = 1'b1;
      if (ek[1]) m_held[gi] = 1'b0;
      m_last = gi;
    end
    for (int v = 0; v < NV; v++) if (b_ret[v]) m_cred[v]++;
    last_gi = gi;
  endtask

  task automatic idle_inputs();
    b_valid = '0;
    b_ret = '0;
    for (int v = 0; v < NV; v++) begin
      b_kind[v] = 2'b00;
      b_data[v] = DW'(16'h1000 * v);
    end
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int v = 0; v < NV; v++) begin
      m_cred[v] = DEPTH;
      m_held[v] = 1'b0;
    end
    m_last = NV - 1;
    #1;
    check(link_valid == 1'b0, "R1", "link_valid after reset", int'(link_valid), 0);
    check(in_ready == '0, "R1", "in_ready after reset", int'(in_ready), 0);
  endtask

  logic [15:0] lf = 16'hACE1;
  function automatic logic [15:0] lf_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  int sends;
  int rem [NV];
  bit inpkt [NV];
  int seq [NV];

  initial begin
    idle_inputs();
    last_gi = -1;

    // R1/R5: full credits at reset, exactly DEPTH flits before stalling
    do_reset();
    @(negedge clk);
    b_valid[0] = 1'b1; b_kind[0] = 2'b01; b_data[0] = 16'h0A01;
    step("R2");
    sends = 1;
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      b_kind[0] = 2'b00; b_data[0] = DW'(16'h0B00 + i);
      step("R5");
      if (last_gi == 0) sends++;
    end
    check(sends == DEPTH, "R1", "flits sent on fresh credits", sends, DEPTH);

    // R6: one return allows exactly one more flit
    @(negedge clk);
    b_ret[0] = 1'b1;
    step("R6");
    @(negedge clk);
    b_ret[0] = 1'b0;
    step("R6");
    check(last_gi == 0, "R6", "flit after credit return", last_gi, 0);
    @(negedge clk);
    step("R6");
    check(last_gi == -1, "R6", "stall after returned credit used", last_gi, -1);

    // R7: overlap of send and return leaves the count, then DEPTH-1 more
    do_reset();
    @(negedge clk);
    b_valid[0] = 1'b1; b_kind[0] = 2'b01; b_data[0] = 16'h0C00;
    step("R7");
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      b_kind[0] = 2'b00; b_ret[0] = 1'b1; b_data[0] = DW'(16'h0C10 + i);
      step("R7");
    end
    sends = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      b_ret[0] = 1'b0;
      step("R7");
      if (last_gi == 0) sends++;
    end
    check(sends == DEPTH - 1, "R7", "credits kept through overlap", sends, DEPTH - 1);

    // R3: continue and close flits on a free lane are held back
    do_reset();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      b_valid[1] = 1'b1; b_kind[1] = (i < 3) ? 2'b00 : 2'b10;
      step("R3");
      check(last_gi == -1, "R3", "flit on free lane", last_gi, -1);
    end

    // R4: open on held lane waits for close; R10: valid low never granted
    do_reset();
    @(negedge clk);
    b_valid[2] = 1'b1; b_kind[2] = 2'b01; b_data[2] = 16'h2001;
    step("R4");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      b_kind[2] = 2'b01; b_data[2] = 16'h2002;
      step("R4");
      check(last_gi == -1, "R4", "open on held lane", last_gi, -1);
    end
    @(negedge clk);
    b_kind[2] = 2'b10; b_data[2] = 16'h2003;
    step("R4");
    @(negedge clk);
    b_kind[2] = 2'b11; b_data[2] = 16'h2004;
    step("R4");
    check(last_gi == 2, "R4", "single after close", last_gi, 2);
    @(negedge clk);
    b_valid = '0; b_kind[3] = 2'b01;
    step("R10");
    check(last_gi == -1, "R10", "grant with no valid", last_gi, -1);

    // R8: all lanes offer singles; grants rotate 0,1,2,3 then wrap
    do_reset();
    for (int i = 0; i < 2 * NV; i++) begin
      @(negedge clk);
      b_valid = '1;
      for (int v = 0; v < NV; v++) begin
        b_kind[v] = 2'b11; b_data[v] = DW'(16'h3000 + 16 * v + i);
      end
      b_ret = '0;
      if (i > 0 && last_gi >= 0) b_ret[last_gi] = 1'b1;
      step("R8");
      check(last_gi == (i % NV), "R8", "round-robin order", last_gi, i % NV);
    end

    // R9/R2: long legal mixed traffic with random returns
    do_reset();
    for (int v = 0; v < NV; v++) begin
      inpkt[v] = 1'b0; rem[v] = 0; seq[v] = 0;
    end
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      for (int v = 0; v < NV; v++) begin
        lf = lf_next(lf);
        b_valid[v] = (lf[2:0] != 3'd0);
        if (!inpkt[v]) begin
          rem[v] = int'(lf[6:5]);
          b_kind[v] = (rem[v] == 0) ? 2'b11 : 2'b01;
        end else begin
          b_kind[v] = (rem[v] > 1) ? 2'b00 : 2'b10;
        end
        b_data[v] = DW'((v << 12) | (seq[v] & 12'hFFF));
        b_ret[v] = lf[9] && (m_cred[v] < DEPTH);
      end
      step("R9");
      if (last_gi >= 0) begin
        int g;
        g = last_gi;
        seq[g]++;
        if (!inpkt[g]) begin
          inpkt[g] = (rem[g] != 0);
        end else begin
          rem[g]--;
          if (rem[g] == 0) inpkt[g] = 1'b0;
        end
      end
    end

    idle_inputs();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule